// File: doc/BRIEF.md
# Page-Mode Parallel Non-Volatile Byte Memory Interface

This block is a cycle-accurate model of the control side of a parallel byte-wide non-volatile memory that is accessed through an asynchronous-SRAM style bus: an active-low chip enable, an active-low write strobe, an active-low output enable, an address and a bidirectional byte lane. The bidirectional lane is split into a data input, a data output and an output enable. All bus pins are sampled on a fast system clock. The analog delays of a real part become clock-cycle counts set by parameters.

The address is divided into a row field in the upper bits and a three-bit column field in the lower bits. The first sampled low level of chip enable latches the row and column and starts a random access. While enable stays low, a new column gives a faster page access, and a new row is spotted by the block itself, which then inserts a precharge interval followed by a fresh random access. Raising chip enable also starts a precharge. Any access request made during a precharge waits until it ends. A write lands in the storage array in the cycle where the write strobe or chip enable is first seen high again, whichever comes first. Writes add no busy time. The storage is an inferred register array. The default address width is 10 bits. Setting `ADDR_W` to 15 gives the full 32768-byte organisation.

Top module: `fram_page_if`

## Requirements
- R1: Address bits [ADDR_W-1:3] select the row and bits [2:0] select one of 8 bytes in that row. A byte written at an address reads back unchanged at that address, and writes at other addresses leave it unchanged.
- R2: Out of reset the bus is not driven. When chip enable is first sampled low from the ready state with the write strobe high, `dq_oe` stays low for that edge and the next T_ACC-1 edges. It rises after the T_ACC-th edge after that first edge, with the addressed byte on `dq_out`.
- R3: With chip enable still low and the row unchanged, a new value on address bits [2:0] drops `dq_oe`. The byte of the new column is driven after T_PAGE edges, counting the edge that sees the change as the first.
- R4: With chip enable low, a new value on the row bits starts a precharge of T_PRE edges, then a random access of T_ACC edges on the new row. The bus comes back after T_PRE+T_ACC edges, counting the edge that sees the change as the first.
- R5: A sampled high chip enable during an access starts a precharge. A low chip enable sampled before the precharge ends starts its access only at the edge T_PRE edges after the one that saw chip enable high.
- R6: The bus is driven only while output enable is low. Raising output enable releases the bus at once, and lowering it again with valid data drives it at once.
- R7: While the write strobe is low, `dq_oe` is low whatever output enable does.
- R8: A write is committed once per strobe, at the first edge where either the write strobe or chip enable is sampled high after the strobe was low. The committed byte is `dq_in` at that edge. A later rise of the other signal writes nothing. When both rise at the same edge, exactly one write occurs.
- R9: With chip enable held low, every further write strobe pulse writes `dq_in` to the current row at the column on address bits [2:0] at its commit edge. After a commit the bus shows that byte after T_PAGE edges.
- R10: Write strobe pulses during a precharge leave the array unchanged, and a precharge never moves straight into an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which all bus pins are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address: row in the upper bits, column in bits [2:0] |
| dq_in | input | DATA_W | Byte lane as seen by the block (write data) |
| dq_out | output | DATA_W | Byte the block presents on the lane |
| dq_oe | output | 1 | High when the block drives the lane |

## Verification
Commit detection and end-of-access handling can fall in the same cycle when the write strobe and chip enable are raised at the same clock edge. The bench provokes this with a strobe-controlled write in which both signals are released together. It then reads the byte back after the precharge and expects the one value written, with no second commit. The opposite ordering is also exercised. The strobe rises first and the data lane then changes before chip enable rises, and the read-back must show the earlier byte. Row-change detection and page-column detection are also driven in cycles that carry write pulses.

// File: rtl/fram_pkg.sv
package fram_pkg;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_PRE    = 2'd1,
        ST_ACCESS = 2'd2
    } fram_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fram_array.sv
module fram_array #(
    parameter int ROW_W  = 7,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Storage has no reset: contents persist, as in a non-volatile part.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_row, wr_col}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_row, rd_col}];

endmodule

// File: rtl/fram_ctrl.sv
module fram_ctrl
    import fram_pkg::*;
#(
    parameter int ROW_W  = 7,
    parameter int COL_W  = 3,
    parameter int T_ACC  = 7,
    parameter int T_PAGE = 3,
    parameter int T_PRE  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    output logic             bus_oe
);
    localparam int CNT_MAX = max3(T_ACC, T_PAGE, T_PRE);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_ACC  = CNT_W'(T_ACC);
    localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(T_PAGE);
    localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        fram_state_e      state;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             we_prev;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  commit;

    // A strobe that was low ends with whichever of WE or CE is seen high first.
    assign commit = (r_q.state == ST_ACCESS) && !r_q.we_prev && (we_n || ce_n);

    always_comb begin
        r_d         = r_q;
        r_d.we_prev = we_n;
        case (r_q.state)
            ST_READY: begin
                if (!ce_n) begin
                    r_d.state = ST_ACCESS;
                    r_d.row   = row_in;
                    r_d.col   = col_in;
                    r_d.cnt   = CNT_ACC;
                    r_d.valid = 1'b0;
                end
            end
            ST_PRE: begin
                if (r_q.cnt <= CNT_ONE) begin
                    r_d.state = ST_READY;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            ST_ACCESS: begin
                if (ce_n || (row_in != r_q.row)) begin
                    r_d.state = ST_PRE;
                    r_d.cnt   = CNT_PRE;
                    r_d.valid = 1'b0;
                end else if (col_in != r_q.col) begin
                    r_d.col   = col_in;
                    r_d.cnt   = CNT_PAGE;
                    r_d.valid = 1'b0;
                end else if (commit) begin
                    r_d.cnt   = CNT_PAGE;
                    r_d.valid = 1'b0;
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                    if (r_q.cnt == CNT_ONE) begin
                        r_d.valid = 1'b1;
                    end
                end
            end
            default: begin
                r_d.state = ST_READY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_READY;
            r_q.row     <= '0;
            r_q.col     <= '0;
            r_q.cnt     <= '0;
            r_q.valid   <= 1'b0;
            r_q.we_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en  = commit;
    assign wr_row = r_q.row;
    assign wr_col = col_in;
    assign rd_row = r_q.row;
    assign rd_col = r_q.col;
    assign bus_oe = (r_q.state == ST_ACCESS) && r_q.valid && !ce_n && !oe_n && we_n;

    // Data becomes valid only when a timed access has run down.
    assert_valid_after_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.valid) |-> ($past(r_q.cnt) == CNT_ONE));

    // A column change within the open row invalidates the presented byte.
    assert_page_switch_invalidates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACCESS && !ce_n && row_in == r_q.row && col_in != r_q.col)
        |=> !r_q.valid);

    // A row change under a low chip enable enters precharge.
    assert_row_change_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACCESS && !ce_n && row_in != r_q.row) |=> (r_q.state == ST_PRE));

    // Precharge ends when its count runs out.
    assert_precharge_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PRE && r_q.cnt <= CNT_ONE) |=> (r_q.state == ST_READY));

    // One commit per strobe.
    assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // Precharge never hands over straight to an access.
    assert_no_access_from_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PRE) |=> (r_q.state != ST_ACCESS));

endmodule

// File: rtl/fram_page_if.sv
module fram_page_if #(
    parameter int ADDR_W = 10,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 7,
    parameter int T_PAGE = 3,
    parameter int T_PRE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic             wr_en;
    logic [ROW_W-1:0] wr_row, rd_row;
    logic [COL_W-1:0] wr_col, rd_col;

    fram_ctrl #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .T_ACC  (T_ACC),
        .T_PAGE (T_PAGE),
        .T_PRE  (T_PRE)
    ) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .row_in (addr[ADDR_W-1:COL_W]),
        .col_in (addr[COL_W-1:0]),
        .wr_en  (wr_en),
        .wr_row (wr_row),
        .wr_col (wr_col),
        .rd_row (rd_row),
        .rd_col (rd_col),
        .bus_oe (dq_oe)
    );

    fram_array #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) i_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (dq_in),
        .rd_row  (rd_row),
        .rd_col  (rd_col),
        .rd_data (dq_out)
    );

    // The lane is never driven while the write strobe is low.
    assert_lane_quiet_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dq_oe);

endmodule

// File: tb/test_fram_page_if.sv
`timescale 1ns/1ps
module test_fram_page_if;
    localparam int ADDR_W = 10;
    localparam int T_ACC  = 7;
    localparam int T_PAGE = 3;
    localparam int T_PRE  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [7:0]        dq_out;
    logic              dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] ref_mem [1 << ADDR_W];

    bit         q_oe  [$];
    logic [7:0] q_dat [$];
    string      q_tag [$];

    always #4 clk = ~clk;

    fram_page_if #(
        .ADDR_W (ADDR_W), .COL_W (3), .DATA_W (8),
        .T_ACC (T_ACC), .T_PAGE (T_PAGE), .T_PRE (T_PRE)
    ) i_fram_page_if (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe)
    );

    // Monitor: compares each expectation with the outputs after its edge.
    always @(posedge clk) begin
        #2;
        while (q_oe.size() > 0) begin
            bit         e_oe;
            logic [7:0] e_dat;
            string      e_tag;
            e_oe  = q_oe.pop_front();
            e_dat = q_dat.pop_front();
            e_tag = q_tag.pop_front();
            checks++;
            if (e_oe) begin
                if (!(dq_oe === 1'b1 && dq_out === e_dat)) begin
                    fails++;
                    $display("FAIL %s: oe=%b data=%h, expected oe=1 data=%h",
                             e_tag, dq_oe, dq_out, e_dat);
                end
            end else if (dq_oe !== 1'b0) begin
                fails++;
                $display("FAIL %s: oe=%b, expected oe=0", e_tag, dq_oe);
            end
        end
    end

    // Driver helpers: called just after a falling clock edge.
    task automatic push(input bit oe, input logic [7:0] d, input string tag);
        q_oe.push_back(oe);
        q_dat.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic step_quiet(input string tag);
        push(1'b0, 8'h00, tag);
        @(negedge clk);
    endtask

    task automatic settle(input int n, input string tag);
        for (int i = 0; i < n; i++) step_quiet(tag);
    endtask

    task automatic expect_run(input int nzero, input logic [7:0] d, input string tag);
        for (int i = 0; i < nzero; i++) step_quiet(tag);
        push(1'b1, d, tag);
        @(negedge clk);
    endtask

    task automatic end_access(input string tag);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        step_quiet(tag);
        settle(T_PRE - 1, tag);
    endtask

    // Write ended by chip enable; the strobe rises later, during precharge.
    task automatic ce_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        step_quiet("R8 ce-write");
        step_quiet("R8 ce-write");
        ce_n = 1'b1;
        step_quiet("R8 ce-write");
        we_n = 1'b1; dq_in = 8'hFF;
        step_quiet("R8 ce-write");
        settle(T_PRE - 2, "R8 ce-write");
        ref_mem[a] = d;
    endtask

    task automatic random_read(input logic [ADDR_W-1:0] a, input string tag);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        expect_run(T_ACC, ref_mem[a], tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step_quiet("R2 reset state");

        // R1/R8: bytes in two rows, writes ended by chip enable
        ce_write(10'h012, 8'hA5);
        ce_write(10'h013, 8'h5A);
        ce_write(10'h3F0, 8'h77);

        // R1/R2: random read timing and data
        random_read(10'h012, "R2 random read");

        // R3: page read of the next column
        addr = 10'h013;
        expect_run(T_PAGE, ref_mem[10'h013], "R3 page read");

        // R6: output enable gating
        oe_n = 1'b1;
        step_quiet("R6 oe high releases");
        oe_n = 1'b0;
        expect_run(0, ref_mem[10'h013], "R6 oe low drives");

        // R7: strobe low keeps the lane quiet, then a strobe-ended write (R9)
        we_n = 1'b0; dq_in = 8'hC3;
        step_quiet("R7 we low quiet");
        we_n = 1'b1;
        step_quiet("R9 commit edge");
        ref_mem[10'h013] = 8'hC3;
        expect_run(T_PAGE - 1, 8'hC3, "R9 read after write");

        // R9: page writes at two further columns
        addr = 10'h014; we_n = 1'b0; dq_in = 8'h3C;
        step_quiet("R9 page write");
        we_n = 1'b1;
        step_quiet("R9 page write");
        ref_mem[10'h014] = 8'h3C;
        addr = 10'h015; we_n = 1'b0; dq_in = 8'h99;
        step_quiet("R9 page write");
        we_n = 1'b1;
        step_quiet("R9 page write");
        ref_mem[10'h015] = 8'h99;
        expect_run(T_PAGE - 1, 8'h99, "R9 page write col5");
        addr = 10'h014;
        expect_run(T_PAGE, 8'h3C, "R9 page write col4");

        // R4: row change under low chip enable
        addr = 10'h3F0;
        expect_run(T_PRE + T_ACC, ref_mem[10'h3F0], "R4 row change");

        // R5/R10: early request and write pulse during precharge
        ce_n = 1'b1; oe_n = 1'b1;
        step_quiet("R5 precharge start");
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 10'h014; dq_in = 8'hEE;
        step_quiet("R10 pulse in precharge");
        we_n = 1'b1;
        step_quiet("R10 pulse in precharge");
        expect_run(T_PRE + T_ACC - 3, 8'h3C, "R5 R10 held-off read");
        end_access("R5 end");

        // R8: strobe and chip enable rise at the same edge
        addr = 10'h020; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        step_quiet("R8 same edge");
        we_n = 1'b0; dq_in = 8'h4B;
        step_quiet("R8 same edge");
        ce_n = 1'b1; we_n = 1'b1;
        step_quiet("R8 same edge");
        settle(T_PRE - 1, "R8 same edge");
        ref_mem[10'h020] = 8'h4B;
        random_read(10'h020, "R8 same edge readback");
        end_access("R8 end");

        // R8: strobe rises first, later chip enable rise writes nothing
        addr = 10'h021; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; dq_in = 8'h11;
        step_quiet("R8 we first");
        we_n = 1'b1;
        step_quiet("R8 we first");
        dq_in = 8'h22; ce_n = 1'b1;
        step_quiet("R8 we first");
        settle(T_PRE - 1, "R8 we first");
        ref_mem[10'h021] = 8'h11;
        random_read(10'h021, "R8 we first readback");
        end_access("R8 end");

        // R1: earlier byte untouched by all later traffic
        random_read(10'h012, "R1 independent byte");
        end_access("R1 end");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule